// File: doc/BRIEF.md
# Address Region Classifier and Access Checker

This block stands in front of the instruction and operand caches. Each cycle it takes one virtual address together with the access kind, the access size, the privilege mode and a handful of cache and translation control bits. It also takes the answer of an external page-table lookup for that address. From these it decides four things:

- whether the access is translated, and what physical address results;
- whether the access may be cached;
- whether a write follows the copy-back or the write-through policy;
- which fault, if any, the access raises.

It also marks data writes that fall in the store-queue window. Those writes bypass the normal checks and are handed on with their address unchanged.

All outputs are registered. The result for the inputs present at a rising clock edge appears after that edge. The block holds no other state, so a new access can be presented every cycle. The page-table lookup itself lives outside the block; only its result enters here.

Top module: `addr_region_checker`

## Requirements
- R1: While `rst` is high at a rising edge, every output is cleared to zero on that edge.
- R2: The region is address bits 31:29. `cacheable` is 1 only when all of these hold:
  - the cache enable for the access kind is set (`icache_en` for fetches, `dcache_en` otherwise);
  - the region is neither 5 nor 7;
  - the access either is untranslated or has `pg_cacheable` set;
  - no error is reported.
- R3: An access is translated only when all of these hold:
  - `xlat_en` is 1;
  - the region is 0, 1, 2, 3 or 6;
  - the address lies outside 0x7C000000–0x7FFFFFFF.

  An access that is not translated reports `paddr` equal to the virtual address.
- R4: Access kind encoding is 0 fetch, 1 data read, 2 data write, 3 data read. A misaligned access reports error code 1.
  - A fetch is misaligned when bit 0 is set, whatever `acc_size` says.
  - A data access is misaligned when its low address bits are not a multiple of its size (`acc_size` 0/1/2/3 = 1/2/4/8 bytes).
- R5: Error code 2 (bad address) is reported in two cases:
  - a privileged (`priv`=1) fetch from region 7;
  - a user-mode data access with address bit 31 set.
- R6: A translated access whose lookup missed (`pg_hit`=0) reports error code 3.
- R7: A translated access reports error code 4 (protection) in two cases:
  - it is in user mode and `pg_prot[1]` is 0;
  - it is a write and `pg_prot[0]` is 0.
- R8: A translated write to a page with `pg_dirty`=0 reports error code 5 (first write).
- R9: `copy_back` is 0 for anything but an error-free write. For such a write it is set as follows:
  - in region 4 it equals `p1_copyback`;
  - elsewhere it equals the inverse of `wthru_sel`;
  - on a translated page it is also forced to 0 when `pg_wthru` is 1.
- R10: When a translated physical address has bits 28:26 all ones, its bits 31:28 are forced to 1 on `paddr`.
- R11: An aligned data write to 0xE0000000–0xE3FFFFFF behaves as follows:
  - `sq_access` is set and `paddr` equals the virtual address;
  - the error code is 0, and privilege and page checks are skipped;
  - `cacheable` and `copy_back` are 0.
- R12: Errors take priority in this order: alignment, then region/privilege, then miss, then protection, then first write. On any error, `cacheable`, `copy_back` and `sq_access` are 0 and `paddr` equals the virtual address.
- R13: Outputs change only at a rising clock edge, one edge after the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vaddr | input | 32 | Virtual address of the access |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| acc_size | input | 2 | Log2 of access size in bytes (data only) |
| priv | input | 1 | 1 = privileged mode, 0 = user mode |
| icache_en | input | 1 | Instruction cache enable |
| dcache_en | input | 1 | Operand cache enable |
| p1_copyback | input | 1 | Copy-back select for region 4 writes |
| wthru_sel | input | 1 | Write-through select for other regions |
| xlat_en | input | 1 | Address translation enable |
| pg_hit | input | 1 | Page lookup found an entry |
| pg_paddr | input | 32 | Physical address from page lookup |
| pg_prot | input | 2 | Page protection: [1] user allowed, [0] writable |
| pg_cacheable | input | 1 | Page may be cached |
| pg_dirty | input | 1 | Page already written |
| pg_wthru | input | 1 | Page demands write-through |
| paddr | output | 32 | Physical address |
| cacheable | output | 1 | Access may use the cache |
| copy_back | output | 1 | Write uses copy-back policy |
| sq_access | output | 1 | Data write in the store-queue window |
| err_code | output | 3 | 0 none, 1 align, 2 bad address, 3 miss, 4 protection, 5 first write |

## Verification
The hardest cases to reach from the ports are those where several faults apply to one access at once. Only the one with the highest priority must show on `err_code`, and lower-ranked faults must stay hidden. Examples are a user-mode misaligned write above 0x80000000, or a user write to a page that is both read-only and clean. The stimulus builds these by setting up the page-lookup inputs and the privilege bit together, then changing one cause at a time so each rank shows in turn. The store-queue window gets the same treatment: it is entered in user mode and with a misaligned address, to confirm that the bypass ranks below the alignment check but above the privilege check.

// File: rtl/arc_pkg.sv
package arc_pkg;
  parameter int ADDR_W   = 32;
  parameter int REGION_W = 3;
  parameter int SIZE_W   = 2;
  parameter int ERR_W    = 3;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_READ2 = 2'd3
  } acc_kind_e;

  typedef enum logic [ERR_W-1:0] {
    ERR_NONE  = 3'd0,
    ERR_ALIGN = 3'd1,
    ERR_BADAD = 3'd2,
    ERR_MISS  = 3'd3,
    ERR_PROT  = 3'd4,
    ERR_FIRST = 3'd5
  } arc_err_e;
endpackage

// File: rtl/arc_region_dec.sv
module arc_region_dec
  import arc_pkg::*;
(
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              is_fetch,
  input  logic              is_write,
  input  logic              priv,
  input  logic              xlat_en,
  output logic              region_cacheable,
  output logic              in_p1,
  output logic              do_xlat,
  output logic              sq_win,
  output logic              priv_fault
);
  localparam int TOP = ADDR_W - 1;
  localparam int RLO = ADDR_W - REGION_W;

  logic [REGION_W-1:0] region;
  logic                bypass_win;
  logic                xlat_region;

  always_comb begin
    region           = vaddr[TOP:RLO];
    region_cacheable = (region != 3'd5) && (region != 3'd7);
    in_p1            = (region == 3'd4);
    xlat_region      = (region <= 3'd3) || (region == 3'd6);
    bypass_win       = (vaddr[TOP:ADDR_W-6] == 6'b011111);
    do_xlat          = xlat_en && xlat_region && !bypass_win;
    sq_win           = is_write && (vaddr[TOP:ADDR_W-6] == 6'b111000);
    if (is_fetch) priv_fault = priv && (region == 3'd7);
    else          priv_fault = !priv && vaddr[TOP];
  end
endmodule

// File: rtl/arc_align_chk.sv
module arc_align_chk
  import arc_pkg::*;
(
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              is_fetch,
  input  logic [SIZE_W-1:0] acc_size,
  output logic              misaligned
);
  localparam int LOW_W = (1 << SIZE_W) - 1;

  logic [LOW_W:0]   size_bytes;
  logic [LOW_W:0]   low_mask;

  always_comb begin
    size_bytes = (LOW_W+1)'(1) << acc_size;
    low_mask   = size_bytes - (LOW_W+1)'(1);
    if (is_fetch) misaligned = vaddr[0];
    else          misaligned = |(vaddr[LOW_W-1:0] & low_mask[LOW_W-1:0]);
  end
endmodule

// File: rtl/arc_page_chk.sv
module arc_page_chk
  import arc_pkg::*;
(
  input  logic              is_write,
  input  logic              priv,
  input  logic              pg_hit,
  input  logic [ADDR_W-1:0] pg_paddr,
  input  logic [1:0]        pg_prot,
  input  logic              pg_dirty,
  output arc_err_e          page_err,
  output logic [ADDR_W-1:0] mapped_pa
);
  localparam int TOP = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] CTRL_SET = {4'hF, {(ADDR_W-4){1'b0}}};

  always_comb begin
    if (!pg_hit)                     page_err = ERR_MISS;
    else if (!priv && !pg_prot[1])   page_err = ERR_PROT;
    else if (is_write && !pg_prot[0]) page_err = ERR_PROT;
    else if (is_write && !pg_dirty)  page_err = ERR_FIRST;
    else                             page_err = ERR_NONE;

    if (pg_paddr[TOP-3:TOP-5] == 3'b111) mapped_pa = pg_paddr | CTRL_SET;
    else                                 mapped_pa = pg_paddr;
  end

  // R8: a first-write fault is only ever produced for a write
  always_comb begin
    a_r8_first_only_write: assert (page_err != ERR_FIRST || is_write);
  end
endmodule

// File: rtl/addr_region_checker.sv
module addr_region_checker
  import arc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       vaddr,
  input  logic [1:0]        acc_kind,
  input  logic [1:0]        acc_size,
  input  logic              priv,
  input  logic              icache_en,
  input  logic              dcache_en,
  input  logic              p1_copyback,
  input  logic              wthru_sel,
  input  logic              xlat_en,
  input  logic              pg_hit,
  input  logic [31:0]       pg_paddr,
  input  logic [1:0]        pg_prot,
  input  logic              pg_cacheable,
  input  logic              pg_dirty,
  input  logic              pg_wthru,
  output logic [31:0]       paddr,
  output logic              cacheable,
  output logic              copy_back,
  output logic              sq_access,
  output logic [2:0]        err_code
);
  logic              is_fetch, is_write;
  logic              region_cacheable, in_p1, do_xlat, sq_win, priv_fault;
  logic              misaligned;
  arc_err_e          page_err, err_n;
  logic [ADDR_W-1:0] mapped_pa, pa_n;
  logic              cach_n, cb_n, sq_n;

  assign is_fetch = (acc_kind == ACC_FETCH);
  assign is_write = (acc_kind == ACC_WRITE);

  arc_region_dec u_region (
    .vaddr(vaddr), .is_fetch(is_fetch), .is_write(is_write), .priv(priv),
    .xlat_en(xlat_en), .region_cacheable(region_cacheable), .in_p1(in_p1),
    .do_xlat(do_xlat), .sq_win(sq_win), .priv_fault(priv_fault)
  );

  arc_align_chk u_align (
    .vaddr(vaddr), .is_fetch(is_fetch), .acc_size(acc_size),
    .misaligned(misaligned)
  );

  arc_page_chk u_page (
    .is_write(is_write), .priv(priv), .pg_hit(pg_hit), .pg_paddr(pg_paddr),
    .pg_prot(pg_prot), .pg_dirty(pg_dirty), .page_err(page_err),
    .mapped_pa(mapped_pa)
  );

  always_comb begin
    sq_n = 1'b0;
    if (misaligned)                 err_n = ERR_ALIGN;
    else if (sq_win) begin
      err_n = ERR_NONE;
      sq_n  = 1'b1;
    end
    else if (priv_fault)            err_n = ERR_BADAD;
    else if (do_xlat)               err_n = page_err;
    else                            err_n = ERR_NONE;

    cach_n = (is_fetch ? icache_en : dcache_en) && region_cacheable &&
             (!do_xlat || pg_cacheable) && (err_n == ERR_NONE) && !sq_n;
    cb_n   = is_write && (err_n == ERR_NONE) && !sq_n &&
             (in_p1 ? p1_copyback : !wthru_sel) && !(do_xlat && pg_wthru);
    pa_n   = ((err_n == ERR_NONE) && do_xlat && !sq_n) ? mapped_pa : vaddr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      paddr     <= '0;
      cacheable <= 1'b0;
      copy_back <= 1'b0;
      sq_access <= 1'b0;
      err_code  <= '0;
    end else begin
      paddr     <= pa_n;
      cacheable <= cach_n;
      copy_back <= cb_n;
      sq_access <= sq_n;
      err_code  <= err_n;
    end
  end

  // R12: any fault suppresses caching, copy-back and the store-queue flag
  a_r12_err_clears: assert property (@(posedge clk) disable iff (rst)
    (err_code != 3'd0) |-> (!cacheable && !copy_back && !sq_access));

  // R11: a store-queue access is fault free, uncached and untranslated
  a_r11_sq_clean: assert property (@(posedge clk) disable iff (rst)
    sq_access |-> (err_code == 3'd0 && !cacheable && paddr == $past(vaddr)));

  // R9: copy-back is only ever reported for a write
  a_r9_cb_write_only: assert property (@(posedge clk) disable iff (rst)
    $past(acc_kind != ACC_WRITE) |-> !copy_back);

  // R4: an odd fetch address always faults on alignment
  a_r4_fetch_odd: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && acc_kind == ACC_FETCH && vaddr[0]) |-> (err_code == 3'd1));

  // R10: a fault-free translated address in the control window lands in the top space
  a_r10_remap: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && do_xlat && !sq_win && pg_paddr[28:26] == 3'b111) && err_code == 3'd0)
      |-> (paddr[31:28] == 4'hF));
endmodule

// File: tb/addr_region_checker_tb.sv
module addr_region_checker_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] vaddr = '0;
  logic [1:0]  acc_kind = '0, acc_size = '0, pg_prot = '0;
  logic        priv = 1'b0, icache_en = 1'b0, dcache_en = 1'b0;
  logic        p1_copyback = 1'b0, wthru_sel = 1'b0, xlat_en = 1'b0;
  logic        pg_hit = 1'b0, pg_cacheable = 1'b0, pg_dirty = 1'b0, pg_wthru = 1'b0;
  logic [31:0] pg_paddr = '0;
  logic [31:0] paddr;
  logic        cacheable, copy_back, sq_access;
  logic [2:0]  err_code;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  addr_region_checker u_dut (
    .clk(clk), .rst(rst), .vaddr(vaddr), .acc_kind(acc_kind), .acc_size(acc_size),
    .priv(priv), .icache_en(icache_en), .dcache_en(dcache_en),
    .p1_copyback(p1_copyback), .wthru_sel(wthru_sel), .xlat_en(xlat_en),
    .pg_hit(pg_hit), .pg_paddr(pg_paddr), .pg_prot(pg_prot),
    .pg_cacheable(pg_cacheable), .pg_dirty(pg_dirty), .pg_wthru(pg_wthru),
    .paddr(paddr), .cacheable(cacheable), .copy_back(copy_back),
    .sq_access(sq_access), .err_code(err_code)
  );

  task automatic benign();
    acc_kind = 2'd1; acc_size = 2'd2; priv = 1'b1;
    icache_en = 1'b1; dcache_en = 1'b1; p1_copyback = 1'b0; wthru_sel = 1'b0;
    xlat_en = 1'b0; pg_hit = 1'b1; pg_paddr = 32'h0C12_3400; pg_prot = 2'b11;
    pg_cacheable = 1'b1; pg_dirty = 1'b1; pg_wthru = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] pa, logic c, logic cb, logic sq, logic [2:0] e);
    total++;
    if (paddr !== pa || cacheable !== c || copy_back !== cb || sq_access !== sq || err_code !== e) begin
      bad++;
      $display("FAIL %s: got pa=%h c=%b cb=%b sq=%b err=%0d, expected pa=%h c=%b cb=%b sq=%b err=%0d",
               req, paddr, cacheable, copy_back, sq_access, err_code, pa, c, cb, sq, e);
    end
  endtask

  task automatic acc(logic [1:0] k, logic [1:0] s, logic [31:0] va);
    acc_kind = k; acc_size = s; vaddr = va;
    step();
  endtask

  task automatic t_reset();
    benign(); vaddr = 32'h0000_1000;
    rst = 1'b1; step();
    chk("R1", 32'h0, 1'b0, 1'b0, 1'b0, 3'd0);
    rst = 1'b0;
  endtask

  task automatic t_cache();
    benign();
    acc(2'd1, 2'd2, 32'h8C00_1000); chk("R2", 32'h8C00_1000, 1'b1, 1'b0, 1'b0, 3'd0);
    acc(2'd1, 2'd2, 32'hAC00_1000); chk("R2", 32'hAC00_1000, 1'b0, 1'b0, 1'b0, 3'd0);
    dcache_en = 1'b0;
    acc(2'd1, 2'd2, 32'h8C00_1000); chk("R2", 32'h8C00_1000, 1'b0, 1'b0, 1'b0, 3'd0);
    acc(2'd0, 2'd1, 32'h2000_0000); chk("R2", 32'h2000_0000, 1'b1, 1'b0, 1'b0, 3'd0);
    dcache_en = 1'b1;
    acc(2'd3, 2'd2, 32'hE400_0000); chk("R2", 32'hE400_0000, 1'b0, 1'b0, 1'b0, 3'd0);
  endtask

  task automatic t_xlat();
    benign(); xlat_en = 1'b1;
    acc(2'd1, 2'd2, 32'h0012_3400); chk("R3", 32'h0C12_3400, 1'b1, 1'b0, 1'b0, 3'd0);
    acc(2'd1, 2'd2, 32'h7C00_0010); chk("R3", 32'h7C00_0010, 1'b1, 1'b0, 1'b0, 3'd0);
    acc(2'd1, 2'd2, 32'h8000_0040); chk("R3", 32'h8000_0040, 1'b1, 1'b0, 1'b0, 3'd0);
    acc(2'd1, 2'd2, 32'hC000_0000); chk("R3", 32'h0C12_3400, 1'b1, 1'b0, 1'b0, 3'd0);
    pg_cacheable = 1'b0;
    acc(2'd1, 2'd2, 32'h0012_3400); chk("R2", 32'h0C12_3400, 1'b0, 1'b0, 1'b0, 3'd0);
  endtask

  task automatic t_align();
    benign();
    acc(2'd1, 2'd2, 32'h0000_0002); chk("R4", 32'h0000_0002, 1'b0, 1'b0, 1'b0, 3'd1);
    acc(2'd1, 2'd3, 32'h0000_0004); chk("R4", 32'h0000_0004, 1'b0, 1'b0, 1'b0, 3'd1);
    acc(2'd1, 2'd1, 32'h0000_0002); chk("R4", 32'h0000_0002, 1'b1, 1'b0, 1'b0, 3'd0);
    acc(2'd0, 2'd1, 32'h0000_0003); chk("R4", 32'h0000_0003, 1'b0, 1'b0, 1'b0, 3'd1);
    acc(2'd0, 2'd2, 32'h0000_0002); chk("R4", 32'h0000_0002, 1'b1, 1'b0, 1'b0, 3'd0);
  endtask

  task automatic t_priv();
    benign(); priv = 1'b0;
    acc(2'd1, 2'd2, 32'h8000_0000); chk("R5", 32'h8000_0000, 1'b0, 1'b0, 1'b0, 3'd2);
    acc(2'd0, 2'd1, 32'hE000_0000); chk("R5", 32'hE000_0000, 1'b0, 1'b0, 1'b0, 3'd0);
    priv = 1'b1;
    acc(2'd0, 2'd1, 32'hE000_0000); chk("R5", 32'hE000_0000, 1'b0, 1'b0, 1'b0, 3'd2);
  endtask

  task automatic t_miss();
    benign(); xlat_en = 1'b1; pg_hit = 1'b0;
    acc(2'd1, 2'd2, 32'h0000_1000); chk("R6", 32'h0000_1000, 1'b0, 1'b0, 1'b0, 3'd3);
    xlat_en = 1'b0;
    acc(2'd1, 2'd2, 32'h0000_1000); chk("R6", 32'h0000_1000, 1'b1, 1'b0, 1'b0, 3'd0);
  endtask

  task automatic t_prot();
    benign(); xlat_en = 1'b1; pg_prot = 2'b01; priv = 1'b0;
    acc(2'd1, 2'd2, 32'h0000_1000); chk("R7", 32'h0000_1000, 1'b0, 1'b0, 1'b0, 3'd4);
    priv = 1'b1;
    acc(2'd1, 2'd2, 32'h0000_1000); chk("R7", 32'h0C12_3400, 1'b1, 1'b0, 1'b0, 3'd0);
    pg_prot = 2'b10;
    acc(2'd2, 2'd2, 32'h0000_1000); chk("R7", 32'h0000_1000, 1'b0, 1'b0, 1'b0, 3'd4);
    pg_prot = 2'b11; pg_dirty = 1'b0;
    acc(2'd2, 2'd2, 32'h0000_1000); chk("R8", 32'h0000_1000, 1'b0, 1'b0, 1'b0, 3'd5);
    acc(2'd1, 2'd2, 32'h0000_1000); chk("R8", 32'h0C12_3400, 1'b1, 1'b0, 1'b0, 3'd0);
  endtask

  task automatic t_copyback();
    benign(); p1_copyback = 1'b1;
    acc(2'd2, 2'd2, 32'h8000_0100); chk("R9", 32'h8000_0100, 1'b1, 1'b1, 1'b0, 3'd0);
    p1_copyback = 1'b0;
    acc(2'd2, 2'd2, 32'h8000_0100); chk("R9", 32'h8000_0100, 1'b1, 1'b0, 1'b0, 3'd0);
    acc(2'd2, 2'd2, 32'h0000_0100); chk("R9", 32'h0000_0100, 1'b1, 1'b1, 1'b0, 3'd0);
    wthru_sel = 1'b1;
    acc(2'd2, 2'd2, 32'h0000_0100); chk("R9", 32'h0000_0100, 1'b1, 1'b0, 1'b0, 3'd0);
    wthru_sel = 1'b0; xlat_en = 1'b1; pg_wthru = 1'b1;
    acc(2'd2, 2'd2, 32'h0000_0100); chk("R9", 32'h0C12_3400, 1'b1, 1'b0, 1'b0, 3'd0);
    pg_wthru = 1'b0;
    acc(2'd2, 2'd2, 32'h0000_0100); chk("R9", 32'h0C12_3400, 1'b1, 1'b1, 1'b0, 3'd0);
    acc(2'd1, 2'd2, 32'h0000_0100); chk("R9", 32'h0C12_3400, 1'b1, 1'b0, 1'b0, 3'd0);
  endtask

  task automatic t_remap();
    benign(); xlat_en = 1'b1;
    pg_paddr = 32'h1C00_0020;
    acc(2'd1, 2'd2, 32'h0000_0020); chk("R10", 32'hFC00_0020, 1'b1, 1'b0, 1'b0, 3'd0);
    pg_paddr = 32'h1BFF_FFE0;
    acc(2'd1, 2'd2, 32'h0000_0020); chk("R10", 32'h1BFF_FFE0, 1'b1, 1'b0, 1'b0, 3'd0);
    pg_paddr = 32'h3C00_0000;
    acc(2'd1, 2'd2, 32'h0000_0020); chk("R10", 32'hFC00_0000, 1'b1, 1'b0, 1'b0, 3'd0);
  endtask

  task automatic t_sq();
    benign();
    acc(2'd2, 2'd2, 32'hE000_0100); chk("R11", 32'hE000_0100, 1'b0, 1'b0, 1'b1, 3'd0);
    priv = 1'b0;
    acc(2'd2, 2'd2, 32'hE000_0100); chk("R11", 32'hE000_0100, 1'b0, 1'b0, 1'b1, 3'd0);
    acc(2'd1, 2'd2, 32'hE000_0100); chk("R11", 32'hE000_0100, 1'b0, 1'b0, 1'b0, 3'd2);
    priv = 1'b1;
    acc(2'd2, 2'd2, 32'hE400_0000); chk("R11", 32'hE400_0000, 1'b0, 1'b1, 1'b0, 3'd0);
    acc(2'd2, 2'd2, 32'hE000_0001); chk("R11", 32'hE000_0001, 1'b0, 1'b0, 1'b0, 3'd1);
  endtask

  task automatic t_prio();
    benign(); priv = 1'b0;
    acc(2'd2, 2'd1, 32'h8000_0001); chk("R12", 32'h8000_0001, 1'b0, 1'b0, 1'b0, 3'd1);
    acc(2'd2, 2'd1, 32'h8000_0000); chk("R12", 32'h8000_0000, 1'b0, 1'b0, 1'b0, 3'd2);
    xlat_en = 1'b1; pg_prot = 2'b00; pg_dirty = 1'b0;
    acc(2'd2, 2'd2, 32'h0040_0000); chk("R12", 32'h0040_0000, 1'b0, 1'b0, 1'b0, 3'd4);
    pg_hit = 1'b0;
    acc(2'd2, 2'd2, 32'h0040_0000); chk("R12", 32'h0040_0000, 1'b0, 1'b0, 1'b0, 3'd3);
  endtask

  task automatic t_latency();
    benign();
    acc(2'd1, 2'd2, 32'h0000_0800);
    vaddr = 32'h0000_0801; acc_kind = 2'd0;
    #1;
    chk("R13", 32'h0000_0800, 1'b1, 1'b0, 1'b0, 3'd0);
    step();
    chk("R13", 32'h0000_0801, 1'b0, 1'b0, 1'b0, 3'd1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_cache();
    t_xlat();
    t_align();
    t_priv();
    t_miss();
    t_prot();
    t_copyback();
    t_remap();
    t_sq();
    t_prio();
    t_latency();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule